// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Interface

This block is the digital front end of a two-channel serial digital-to-analog converter. A host writes 16-bit frames over an SPI-style link while holding an active-low select low. Each frame picks channel A or channel B. It loads that channel's input register with three things: a data code, a full-scale gain choice and an active/shutdown choice.

The input registers do not reach the converter directly. A separate active-low latch strobe copies both input registers into the output registers on one system clock edge, so the two analog outputs change together. When the latch strobe is tied low, each accepted frame reaches the outputs right after select is released.

All serial and strobe inputs are brought into the system clock domain through synchronisers and then edge-detected. The converter resolution is a parameter of 8, 10 or 12 bits. The block presents the output-register contents as parallel code, gain and shutdown signals for each channel.

Top module: `dac2_serial_front`

## Requirements
- R1: After reset, both channels report shutdown (`shdn_*` = 1), a zero code and 2x gain (`gain_x2_*` = 1).
- R2: A frame is 16 bits, sent MSB first and sampled on rising `sclk`. Frame bit 15 selects the target channel (0 = A, 1 = B). Only the target channel's input register is written, and the write happens when `cs_n` rises.
- R3: Frame bit 13 chooses gain: 0 gives 2x (`gain_x2` = 1) and 1 gives 1x (`gain_x2` = 0).
- R4: Frame bit 12 is an active-low shutdown control: 0 puts that channel alone into shutdown (`shdn` = 1) and 1 makes it active. The other channel is left untouched.
- R5: Frame bits 11..0 carry the code left-justified. The output code is bits 11 down to 12-RES_BITS, and the lower bits are dropped at 8-bit and 10-bit resolution.
- R6: A frame that sees fewer or more than 16 rising `sclk` edges while `cs_n` is low is discarded, and both input registers keep their contents.
- R7: A falling edge on `latch_n` copies both input registers into both output registers on the same clock edge.
- R8: While `latch_n` is held low, an accepted frame reaches the outputs after `cs_n` rises, and not before.
- R9: Frame bit 14 has no effect on any output.
- R10: `sclk` edges while `cs_n` is high are not counted and do not corrupt the next frame.
- R11: Without a latch transfer, a new frame leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data, MSB first |
| latch_n | input | 1 | Active-low transfer strobe |
| code_a | output | RES_BITS | Channel A output-register code |
| code_b | output | RES_BITS | Channel B output-register code |
| gain_x2_a | output | 1 | Channel A full scale is 2x the reference |
| gain_x2_b | output | 1 | Channel B full scale is 2x the reference |
| shdn_a | output | 1 | Channel A in shutdown |
| shdn_b | output | 1 | Channel B in shutdown |

## Verification
Some properties are checked on every cycle:
- the outputs stay frozen in any cycle without a transfer;
- a transfer lands each channel's input register on its outputs one edge later;
- at most one input register is written at a time;
- a write is accepted only once select is high;
- the edge counter stays bounded.

Other behaviour is only visible through the bench's scenarios:
- the frame bit positions and their encodings;
- the rejection of short and long frames;
- sclk noise while deselected;
- the same-cycle update of both channels;
- the held-low latch path that updates on select release.

// File: rtl/dac2_pkg.sv
package dac2_pkg;
  localparam int FRAME_LEN = 16;
  localparam int MAX_RES   = 12;
  localparam int NUM_CH    = 2;
  // frame field positions (decoded by the receiver)
  localparam int CH_BIT    = 15;
  localparam int GAIN_BIT  = 13;
  localparam int ACT_BIT   = 12;
  localparam int DATA_MSB  = 11;

  typedef struct packed {
    logic [MAX_RES-1:0] code;
    logic               gain_x2;
    logic               active;
  } chan_word_t;

  localparam chan_word_t CHAN_RESET = '{code: '0, gain_x2: 1'b1, active: 1'b0};
endpackage

// File: rtl/dac2_sync.sv
module dac2_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;
  logic              prev_q;

  always_comb pipe_d = {pipe_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl  = pipe_q[STAGES-1];
  assign rise = pipe_q[STAGES-1] & ~prev_q;
  assign fall = ~pipe_q[STAGES-1] & prev_q;
endmodule

// File: rtl/dac2_frame_rx.sv
module dac2_frame_rx import dac2_pkg::*; #(
  parameter int FRAME_BITS = FRAME_LEN,
  parameter int CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             sel_rise,
  input  logic             sclk_rise,
  input  logic             sdi_bit,
  output logic             wr_valid,
  output logic             wr_chan,
  output chan_word_t       wr_word,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (sel_n) begin
      cnt_d = '0;
    end else if (sclk_rise) begin
      shreg_d = {shreg_q[FRAME_BITS-2:0], sdi_bit};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign wr_valid        = sel_rise && (cnt_q == CNT_FULL);
  assign wr_chan         = shreg_q[CH_BIT];
  assign wr_word.code    = shreg_q[DATA_MSB:0];
  assign wr_word.gain_x2 = ~shreg_q[GAIN_BIT];
  assign wr_word.active  = shreg_q[ACT_BIT];
  assign bit_cnt         = cnt_q;
endmodule

// File: rtl/dac2_chan_regs.sv
module dac2_chan_regs import dac2_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] wr_en,
  input  chan_word_t        wr_word,
  input  logic              xfer,
  output chan_word_t        in_q  [NUM_CH],
  output chan_word_t        out_q [NUM_CH]
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    chan_word_t in_d, out_d;

    always_comb begin
      in_d  = wr_en[ch] ? wr_word : in_q[ch];
      out_d = xfer ? in_q[ch] : out_q[ch];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q[ch]  <= CHAN_RESET;
        out_q[ch] <= CHAN_RESET;
      end else begin
        in_q[ch]  <= in_d;
        out_q[ch] <= out_d;
      end
    end
  end
endmodule

// File: rtl/dac2_serial_front.sv
module dac2_serial_front import dac2_pkg::*; #(
  parameter int RES_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                sdi,
  input  logic                latch_n,
  output logic [RES_BITS-1:0] code_a,
  output logic [RES_BITS-1:0] code_b,
  output logic                gain_x2_a,
  output logic                gain_x2_b,
  output logic                shdn_a,
  output logic                shdn_b
);
  localparam int         CNT_W     = $clog2(FRAME_LEN + 2);
  localparam int         NSYNC     = 4;
  // index: 0 sclk, 1 sdi, 2 cs_n, 3 latch_n
  localparam logic [3:0] SYNC_IDLE = 4'b1100;

  if (!(RES_BITS == 8 || RES_BITS == 10 || RES_BITS == 12)) begin : g_bad_res
    $error("RES_BITS must be 8, 10 or 12");
  end

  logic [NSYNC-1:0] raw_in, s_lvl, s_rise, s_fall;
  assign raw_in = {latch_n, cs_n, sdi, sclk};

  for (genvar i = 0; i < NSYNC; i++) begin : g_sync
    dac2_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE[i])) u_sync (
      .clk (clk), .rst_n(rst_n), .d(raw_in[i]),
      .lvl (s_lvl[i]), .rise(s_rise[i]), .fall(s_fall[i])
    );
  end

  logic             wr_valid, wr_chan;
  chan_word_t       wr_word;
  logic [CNT_W-1:0] bit_cnt;

  dac2_frame_rx #(.FRAME_BITS(FRAME_LEN), .CNT_W(CNT_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (s_lvl[2]),
    .sel_rise (s_rise[2]),
    .sclk_rise(s_rise[0]),
    .sdi_bit  (s_lvl[1]),
    .wr_valid (wr_valid),
    .wr_chan  (wr_chan),
    .wr_word  (wr_word),
    .bit_cnt  (bit_cnt)
  );

  logic [NUM_CH-1:0] wr_en;
  logic              commit_q, xfer;

  always_comb begin
    wr_en = '0;
    if (wr_valid) wr_en[wr_chan] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_q <= 1'b0;
    else        commit_q <= wr_valid;
  end

  // strobe edge, or held-low strobe after a freshly committed frame
  assign xfer = s_fall[3] | (~s_lvl[3] & commit_q);

  chan_word_t in_q  [NUM_CH];
  chan_word_t out_q [NUM_CH];

  dac2_chan_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_word(wr_word),
    .xfer   (xfer),
    .in_q   (in_q),
    .out_q  (out_q)
  );

  chan_word_t in_a, in_b;
  assign in_a = in_q[0];
  assign in_b = in_q[1];

  assign code_a    = out_q[0].code[MAX_RES-1 -: RES_BITS];
  assign code_b    = out_q[1].code[MAX_RES-1 -: RES_BITS];
  assign gain_x2_a = out_q[0].gain_x2;
  assign gain_x2_b = out_q[1].gain_x2;
  assign shdn_a    = ~out_q[0].active;
  assign shdn_b    = ~out_q[1].active;
endmodule

// File: rtl/dac2_front_checker.sv
module dac2_front_checker import dac2_pkg::*; #(
  parameter int RES_BITS = 12,
  parameter int CNT_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                xfer,
  input logic [NUM_CH-1:0]   wr_en,
  input logic                wr_valid,
  input logic                sel_n,
  input logic [CNT_W-1:0]    bit_cnt,
  input chan_word_t          in_a,
  input chan_word_t          in_b,
  input logic [RES_BITS-1:0] code_a,
  input logic [RES_BITS-1:0] code_b,
  input logic                gain_x2_a,
  input logic                gain_x2_b,
  input logic                shdn_a,
  input logic                shdn_b
);
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable({code_a, code_b, gain_x2_a, gain_x2_b, shdn_a, shdn_b}));

  assert_xfer_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (code_a == $past(in_a.code[MAX_RES-1 -: RES_BITS])) &&
             (gain_x2_a == $past(in_a.gain_x2)) && (shdn_a == !$past(in_a.active)));

  assert_xfer_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (code_b == $past(in_b.code[MAX_RES-1 -: RES_BITS])) &&
             (gain_x2_b == $past(in_b.gain_x2)) && (shdn_b == !$past(in_b.active)));

  assert_one_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  assert_write_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> sel_n);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_LEN + 1));
endmodule

bind dac2_serial_front dac2_front_checker #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .xfer     (xfer),
  .wr_en    (wr_en),
  .wr_valid (wr_valid),
  .sel_n    (s_lvl[2]),
  .bit_cnt  (bit_cnt),
  .in_a     (in_a),
  .in_b     (in_b),
  .code_a   (code_a),
  .code_b   (code_b),
  .gain_x2_a(gain_x2_a),
  .gain_x2_b(gain_x2_b),
  .shdn_a   (shdn_a),
  .shdn_b   (shdn_b)
);

// File: tb/test_dac2_serial_front.sv
module test_dac2_serial_front;
  localparam int RES = 12;
  localparam int NV  = 6;
  localparam logic [15:0] VEC_WORD [NV] = '{16'h1ABC, 16'h9123, 16'h2FFF, 16'hF000, 16'h7555, 16'h8800};
  localparam logic        VEC_CH   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [11:0] VEC_CODE [NV] = '{12'hABC, 12'h123, 12'hFFF, 12'h000, 12'h555, 12'h800};
  localparam logic        VEC_G2   [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic        VEC_SD   [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  logic clk, rst_n, cs_n, sclk, sdi, latch_n;
  logic [RES-1:0] code_a, code_b;
  logic gain_x2_a, gain_x2_b, shdn_a, shdn_b;

  int tests, fails;
  bit done;
  logic [11:0] m_code [2];
  logic        m_g2 [2];
  logic        m_sd [2];

  dac2_serial_front #(.RES_BITS(RES)) i_dac2_serial_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .latch_n(latch_n),
    .code_a(code_a), .code_b(code_b), .gain_x2_a(gain_x2_a), .gain_x2_b(gain_x2_b),
    .shdn_a(shdn_a), .shdn_b(shdn_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "code_a", 16'(code_a), 16'(m_code[0]));
    check(tag, "gain_x2_a", 16'(gain_x2_a), 16'(m_g2[0]));
    check(tag, "shdn_a", 16'(shdn_a), 16'(m_sd[0]));
    check(tag, "code_b", 16'(code_b), 16'(m_code[1]));
    check(tag, "gain_x2_b", 16'(gain_x2_b), 16'(m_g2[1]));
    check(tag, "shdn_b", 16'(shdn_b), 16'(m_sd[1]));
  endtask

  task automatic shift_bits(input logic [15:0] word, input int n);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? word[15 - i] : 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic send_frame(input logic [15:0] word, input int n);
    shift_bits(word, n);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic pulse_latch();
    latch_n = 1'b0;
    wait_clk(8);
    latch_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run state actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int ca, cb;
    tests = 0; fails = 0; done = 0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; latch_n = 1'b1;
    for (int c = 0; c < 2; c++) begin
      m_code[c] = '0; m_g2[c] = 1'b1; m_sd[c] = 1'b1;
    end
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check_all("R1");

    // vector table: frame, then strobe, then all outputs (vector 3 and 4 set bit 14: R9)
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC_WORD[v], 16);
      pulse_latch();
      m_code[VEC_CH[v]] = VEC_CODE[v];
      m_g2[VEC_CH[v]]   = VEC_G2[v];
      m_sd[VEC_CH[v]]   = VEC_SD[v];
      check_all("R2/R3/R4/R5/R9");
    end

    // R11: frames without a strobe leave the outputs alone
    send_frame(16'h1111, 16);
    check_all("R11");
    send_frame(16'h9222, 16);
    check_all("R11");

    // R7: one strobe moves both channels on the same cycle
    latch_n = 1'b0;
    ca = -1; cb = -1;
    for (int k = 0; k < 10; k++) begin
      wait_clk(1);
      if (ca < 0 && code_a == 12'h111) ca = k;
      if (cb < 0 && code_b == 12'h222) cb = k;
    end
    latch_n = 1'b1;
    wait_clk(8);
    check("R7", "update cycle A vs B", 16'(ca), 16'(cb));
    m_code[0] = 12'h111; m_g2[0] = 1'b1; m_sd[0] = 1'b0;
    m_code[1] = 12'h222; m_g2[1] = 1'b1; m_sd[1] = 1'b0;
    check_all("R7");

    // R6: short and long frames are discarded
    send_frame(16'h1333, 15);
    pulse_latch();
    check_all("R6 short");
    send_frame(16'h9333, 17);
    pulse_latch();
    check_all("R6 long");

    // R10: sclk noise with select high
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
    end
    send_frame(16'h9444, 16);
    pulse_latch();
    m_code[1] = 12'h444;
    check_all("R10");

    // R8: strobe held low, update follows select release
    latch_n = 1'b0;
    wait_clk(8);
    shift_bits(16'h3555, 16);
    check_all("R8 before release");
    cs_n = 1'b1;
    wait_clk(10);
    m_code[0] = 12'h555; m_g2[0] = 1'b0; m_sd[0] = 1'b0;
    check_all("R8 after release");
    latch_n = 1'b1;
    wait_clk(8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule